// File: doc/BRIEF.md
# Byte-Lane Host Buffer Interface

This block sits between a 32-bit host bus and the packet buffer of a network add-on board. The host reaches the buffer through a single data word (word 0 of the buffer window) whose byte lanes carry different meanings. The lowest lane moves bytes in and out through two independent auto-incrementing pointers. Lane 1 rewinds both pointers. Lane 2 loads an auxiliary control byte. The top lane loads a mode byte and passes it, bit-reversed, to the board's configuration logic. When more than one lane is enabled, a fixed priority picks the single lane that acts.

A second address window, selected by `win`, holds a status port. One word of that window reports whether configuration data has been pushed. Every other word in the status window reads as all ones, and writes to that window do nothing. Each request is a one-cycle pulse on `req`, and it is acknowledged exactly one cycle later. Read data arrives together with the acknowledge because the buffer RAM has a registered output.

The buffer size is set by `PTR_W` (bytes = 2^PTR_W). A 32 KiB board buffer uses `PTR_W = 15`. The default is smaller so that it elaborates quickly.

Top module: `pktbuf_host`

## Requirements
- R1: Reset clears both pointers, the mode, rewind and auxiliary bytes and the loaded flag, and holds `ack` and `cfg_valid` low. Buffer contents survive a reset.
- R2: A write to buffer word 0 (`win`=0, `waddr`=0) that acts on lane 0 (`be[0]`, data bits 7:0) stores the byte at the write pointer and then advances the pointer by one. The pointer wraps modulo 2^PTR_W.
- R3: A read of buffer word 0 with `be[0]` set returns {24'h0, byte at read pointer} with the acknowledge, then advances the read pointer by one, modulo 2^PTR_W.
- R4: A read of buffer word 0 with `be[0]` clear returns 32'hFFFFFF00 and leaves the read pointer unchanged.
- R5: A word-0 write that acts on lane 1 (`be[1]`, bits 15:8) sets both pointers to zero and puts the byte on `rst_byte`.
- R6: A word-0 write that acts on lane 3 (`be[3]`, bits 31:24) puts the byte on `mode_byte` and sets the loaded flag. One cycle later, `cfg_valid` pulses for one cycle with `cfg_byte` bit i equal to data bit 31-i.
- R7: A word-0 write that acts on lane 2 (`be[2]`, bits 23:16) puts the byte on `aux_byte`. If `mode_byte` is nonzero at that time, buffer byte 2 becomes {4'h0, data bits 23:20} and buffer byte 3 becomes 0. Otherwise the buffer is unchanged.
- R8: On a word-0 write, only the first enabled lane in the order lane 3, lane 1, lane 2, lane 0 takes effect.
- R9: A read of status word 16 (byte offset 0x40) returns a word whose bit 30 is the loaded flag and whose bit 29 is 1. All other bits are 0, so the word is 0x20000000 or 0x60000000.
- R10: Reads of any other status word return 32'hFFFFFFFF. Writes to the status window change no pointer, control byte or flag.
- R11: Every request is acknowledged by a one-cycle `ack` in the next cycle. Buffer-window words other than 0 read as 0 and ignore writes.
- R12: The loaded flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | One-cycle access request |
| we | input | 1 | 1 = write, 0 = read |
| win | input | 1 | 0 = buffer window, 1 = status window |
| waddr | input | ADDR_W | Word index within the window |
| be | input | 4 | Byte enables, bit n = bits 8n+7:8n |
| wdata | input | 32 | Write data |
| ack | output | 1 | Acknowledge, one cycle after `req` |
| rdata | output | 32 | Read data, valid with `ack` |
| cfg_valid | output | 1 | Pulse carrying a configuration byte |
| cfg_byte | output | 8 | Bit-reversed configuration byte |
| mode_byte | output | 8 | Last top-lane byte |
| rst_byte | output | 8 | Last rewind-lane byte |
| aux_byte | output | 8 | Last lane-2 byte |

## Verification
The hardest state to reach is a lane-2 write while the mode byte is nonzero. That needs a top-lane write first, and the side effect it has on buffer bytes 2 and 3 only becomes visible after a rewind followed by four sequential reads. The bench reaches it after sweeping all 256 top-lane values, and then sweeps every byte-enable combination on word 0 against a running model. It also drives the pointers past the wrap point, so reads can return bytes that were overwritten during the wrap. A second reset mid-run then shows that the flag clears while the buffer keeps its data.

// File: rtl/pktbuf_pkg.sv
package pktbuf_pkg;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_CFG,
      OP_CLR,
      OP_AUX,
      OP_PUT,
      OP_GET
   } op_e;

   function automatic logic [31:0] status_word(input logic loaded);
      status_word = {1'b0, loaded, 1'b1, 29'b0};
   endfunction

endpackage

// File: rtl/pktbuf_decode.sv
module pktbuf_decode
   import pktbuf_pkg::*;
#(
   parameter int ADDR_W = 14
) (
   input  logic              req,
   input  logic              we,
   input  logic              win,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [3:0]        be,
   output op_e               op
);

   logic word0;
   assign word0 = (waddr == '0) && !win;

   // fixed lane priority: 3, 1, 2, 0
   always_comb begin
      op = OP_NONE;
      if (req && word0) begin
         if (we) begin
            if (be[3])      op = OP_CFG;
            else if (be[1]) op = OP_CLR;
            else if (be[2]) op = OP_AUX;
            else if (be[0]) op = OP_PUT;
         end else if (be[0]) begin
            op = OP_GET;
         end
      end
   end

endmodule

// File: rtl/pktbuf_ptr.sv
module pktbuf_ptr #(
   parameter int W = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n)   q <= '0;
      else if (clr) q <= '0;
      else if (inc) q <= q + W'(1);
   end

   assert_step_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr) |=> (q == W'($past(q) + W'(1))));

   assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (q == '0));

endmodule

// File: rtl/pktbuf_bank.sv
module pktbuf_bank #(
   parameter int IDX_W = 10
) (
   input  logic             clk,
   input  logic             en,
   input  logic             wr,
   input  logic [IDX_W-1:0] idx,
   input  logic [7:0]       din,
   output logic [7:0]       dout
);

   localparam int DEPTH = 1 << IDX_W;

   logic [7:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (en) begin
         if (wr) cells[idx] <= din;
         else    dout <= cells[idx];
      end
   end

endmodule

// File: rtl/pktbuf_host.sv
module pktbuf_host
   import pktbuf_pkg::*;
#(
   parameter int PTR_W     = 11,
   parameter int ADDR_W    = 14,
   parameter int STAT_WORD = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              we,
   input  logic              win,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [3:0]        be,
   input  logic [31:0]       wdata,
   output logic              ack,
   output logic [31:0]       rdata,
   output logic              cfg_valid,
   output logic [7:0]        cfg_byte,
   output logic [7:0]        mode_byte,
   output logic [7:0]        rst_byte,
   output logic [7:0]        aux_byte
);

   localparam int IDX_W = PTR_W - 1;
   localparam int NBANK = 2;

   if (PTR_W < 3 || PTR_W > 20) begin : g_bad_ptr
      $error("pktbuf_host: PTR_W out of range");
   end
   if ((1 << ADDR_W) <= STAT_WORD) begin : g_bad_addr
      $error("pktbuf_host: ADDR_W too narrow for status word");
   end

   op_e op;
   pktbuf_decode #(.ADDR_W(ADDR_W)) u_dec (
      .req  (req),
      .we   (we),
      .win  (win),
      .waddr(waddr),
      .be   (be),
      .op   (op)
   );

   logic [PTR_W-1:0] rp_q, wp_q;
   logic             clr_both;
   assign clr_both = (op == OP_CLR);

   pktbuf_ptr #(.W(PTR_W)) u_rptr (
      .clk(clk), .rst_n(rst_n), .clr(clr_both), .inc(op == OP_GET), .q(rp_q)
   );
   pktbuf_ptr #(.W(PTR_W)) u_wptr (
      .clk(clk), .rst_n(rst_n), .clr(clr_both), .inc(op == OP_PUT), .q(wp_q)
   );

   logic loaded_q;
   logic fill;
   assign fill = (op == OP_AUX) && (mode_byte != 8'h00);

   // bytes are banked by address bit 0 so bytes 2 and 3 are written together
   logic [7:0] bank_q [NBANK];
   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic             wr_b, rd_b;
      logic [IDX_W-1:0] idx_b;
      logic [7:0]       din_b;
      assign wr_b  = ((op == OP_PUT) && (wp_q[0] == 1'(b))) || fill;
      assign rd_b  = (op == OP_GET) && (rp_q[0] == 1'(b));
      assign idx_b = fill ? IDX_W'(1) :
                     (op == OP_PUT) ? wp_q[PTR_W-1:1] : rp_q[PTR_W-1:1];
      if (b == 0) begin : g_lo
         assign din_b = fill ? {4'h0, wdata[23:20]} : wdata[7:0];
      end else begin : g_hi
         assign din_b = fill ? 8'h00 : wdata[7:0];
      end
      pktbuf_bank #(.IDX_W(IDX_W)) u_bank (
         .clk (clk),
         .en  (wr_b || rd_b),
         .wr  (wr_b),
         .idx (idx_b),
         .din (din_b),
         .dout(bank_q[b])
      );
   end

   logic [7:0] rev;
   for (genvar i = 0; i < 8; i++) begin : g_rev
      assign rev[i] = wdata[31-i];
   end

   logic [31:0] imm_next, imm_q;
   logic        from_ram_q, rsel_q;

   always_comb begin
      if (win)
         imm_next = (waddr == ADDR_W'(STAT_WORD)) ? status_word(loaded_q) : '1;
      else if (waddr == '0)
         imm_next = 32'hFFFF_FF00;
      else
         imm_next = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack        <= 1'b0;
         cfg_valid  <= 1'b0;
         cfg_byte   <= '0;
         mode_byte  <= '0;
         rst_byte   <= '0;
         aux_byte   <= '0;
         loaded_q   <= 1'b0;
         imm_q      <= '0;
         from_ram_q <= 1'b0;
         rsel_q     <= 1'b0;
      end else begin
         ack       <= req;
         cfg_valid <= (op == OP_CFG);
         if (op == OP_CFG) begin
            mode_byte <= wdata[31:24];
            cfg_byte  <= rev;
            loaded_q  <= 1'b1;
         end
         if (op == OP_CLR) rst_byte <= wdata[15:8];
         if (op == OP_AUX) aux_byte <= wdata[23:16];
         if (req && !we) begin
            from_ram_q <= (op == OP_GET);
            imm_q      <= imm_next;
         end
         if (op == OP_GET) rsel_q <= rp_q[0];
      end
   end

   assign rdata = from_ram_q ? {24'h0, bank_q[rsel_q]} : imm_q;

   assert_loaded_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
      loaded_q |=> loaded_q);

   assert_cfg_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid |-> loaded_q);

   assert_rewind_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_both |=> (rp_q == '0 && wp_q == '0));

   assert_status_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req && win) |=> ($stable(rp_q) && $stable(wp_q) && $stable(mode_byte)
                        && $stable(aux_byte) && $stable(rst_byte)));

   assert_miss_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !we && !win && waddr == '0 && !be[0]) |=> $stable(rp_q));

   assert_ack_once_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !req) |=> !ack);

endmodule

// File: tb/pktbuf_host_test.sv
`timescale 1ns/1ps
module pktbuf_host_test;

   localparam int PTR_W = 6;
   localparam int ADDR_W = 6;
   localparam int DEPTH = 1 << PTR_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req = 1'b0, we = 1'b0, win = 1'b0;
   logic [ADDR_W-1:0] waddr = '0;
   logic [3:0]  be = '0;
   logic [31:0] wdata = '0;
   logic        ack, cfg_valid;
   logic [31:0] rdata;
   logic [7:0]  cfg_byte, mode_byte, rst_byte, aux_byte;

   always #2 clk = ~clk;

   pktbuf_host #(.PTR_W(PTR_W), .ADDR_W(ADDR_W), .STAT_WORD(16)) uut (
      .clk(clk), .rst_n(rst_n), .req(req), .we(we), .win(win), .waddr(waddr),
      .be(be), .wdata(wdata), .ack(ack), .rdata(rdata), .cfg_valid(cfg_valid),
      .cfg_byte(cfg_byte), .mode_byte(mode_byte), .rst_byte(rst_byte),
      .aux_byte(aux_byte)
   );

   int n_cmp = 0, n_bad = 0;
   logic [7:0] mem_m [DEPTH];
   bit         known [DEPTH];
   int         rp_m, wp_m;
   logic [7:0] mode_m, rst_m, aux_m;
   logic       loaded_m;

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %08h expected %08h at %0t", tag, got, exp, $time);
      end
   endtask

   function automatic logic [7:0] rev8(input logic [7:0] v);
      logic [7:0] r = '0;
      for (int i = 0; i < 8; i++) r = r | 8'(((v >> i) & 8'h01) << (7 - i));
      return r;
   endfunction

   task automatic do_reset();
      req = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      rp_m = 0; wp_m = 0;
      mode_m = '0; rst_m = '0; aux_m = '0; loaded_m = 1'b0;
      @(negedge clk);
      check("R1", 32'(ack), 32'd0);
      check("R1", 32'(cfg_valid), 32'd0);
      check("R1", 32'({mode_byte, rst_byte, aux_byte}), 32'd0);
   endtask

   // one access; called at a negedge, returns at the next negedge
   task automatic bus(input string tag, input logic stat, input int a,
                      input logic wr, input logic [3:0] b, input logic [31:0] d);
      logic [31:0] exp_r = '0;
      logic        chk_r = !wr;
      logic        exp_cfg = 1'b0;
      logic [7:0]  exp_cb = '0;
      req = 1'b1; we = wr; win = stat; waddr = ADDR_W'(a); be = b; wdata = d;
      if (stat) begin
         if (!wr) exp_r = (a == 16) ? (loaded_m ? 32'h6000_0000 : 32'h2000_0000)
                                    : 32'hFFFF_FFFF;
      end else if (a != 0) begin
         exp_r = '0;
      end else if (!wr) begin
         if (b[0]) begin
            if (known[rp_m]) exp_r = {24'h0, mem_m[rp_m]};
            else chk_r = 1'b0;
            rp_m = (rp_m + 1) % DEPTH;
         end else begin
            exp_r = 32'hFFFF_FF00;
         end
      end else if (b[3]) begin
         mode_m = d[31:24]; loaded_m = 1'b1; exp_cfg = 1'b1; exp_cb = rev8(d[31:24]);
      end else if (b[1]) begin
         rp_m = 0; wp_m = 0; rst_m = d[15:8];
      end else if (b[2]) begin
         if (mode_m != 8'h00) begin
            mem_m[2] = {4'h0, d[23:20]}; known[2] = 1'b1;
            mem_m[3] = 8'h00;            known[3] = 1'b1;
         end
         aux_m = d[23:16];
      end else if (b[0]) begin
         mem_m[wp_m] = d[7:0]; known[wp_m] = 1'b1;
         wp_m = (wp_m + 1) % DEPTH;
      end
      @(negedge clk);
      check("R11", 32'(ack), 32'd1);
      if (chk_r) check(tag, rdata, exp_r);
      check(tag, 32'(cfg_valid), 32'(exp_cfg));
      if (exp_cfg) check(tag, 32'(cfg_byte), 32'(exp_cb));
      check(tag, 32'({mode_byte, rst_byte, aux_byte}), 32'({mode_m, rst_m, aux_m}));
      req = 1'b0;
   endtask

   task automatic idle();
      @(negedge clk);
      check("R11", 32'(ack), 32'd0);
   endtask

   initial begin
      for (int i = 0; i < DEPTH; i++) known[i] = 1'b0;
      do_reset();
      // R1/R9: status after reset
      bus("R9", 1'b1, 16, 1'b0, 4'hF, '0);
      // R10: sweep of every status word, then ignored writes
      for (int a = 0; a < (1 << ADDR_W); a++) bus("R10", 1'b1, a, 1'b0, 4'hF, '0);
      for (int a = 0; a < 20; a++) bus("R10", 1'b1, a, 1'b1, 4'hF, 32'hFFFF_FFFF);
      bus("R10", 1'b1, 16, 1'b0, 4'hF, '0);
      idle();
      // R2: fill past the wrap point
      for (int i = 0; i < DEPTH + 6; i++)
         bus("R2", 1'b0, 0, 1'b1, 4'h1, 32'((i * 37 + 5) & 255));
      // R5: rewind both, then R3 sequential read with wrap
      bus("R5", 1'b0, 0, 1'b1, 4'h2, 32'h0000_5A00);
      for (int i = 0; i < DEPTH + 3; i++) bus("R3", 1'b0, 0, 1'b0, 4'h1, '0);
      // R4: reads without lane 0 leave pointer alone
      bus("R4", 1'b0, 0, 1'b0, 4'h0, '0);
      bus("R4", 1'b0, 0, 1'b0, 4'h2, '0);
      bus("R4", 1'b0, 0, 1'b0, 4'hE, '0);
      bus("R4", 1'b0, 0, 1'b0, 4'h1, '0);
      idle();
      // R11: other buffer words read zero, writes ignored
      for (int a = 1; a < 4; a++) bus("R11", 1'b0, a, 1'b1, 4'hF, 32'hDEAD_BEEF);
      for (int a = 1; a < 4; a++) bus("R11", 1'b0, a, 1'b0, 4'hF, '0);
      // R7: lane 2 with mode zero leaves buffer
      bus("R7", 1'b0, 0, 1'b1, 4'h4, 32'h00C3_0000);
      bus("R5", 1'b0, 0, 1'b1, 4'h2, 32'h0000_0100);
      for (int i = 0; i < 4; i++) bus("R7", 1'b0, 0, 1'b0, 4'h1, '0);
      // R6: every configuration byte value
      for (int v = 0; v < 256; v++) bus("R6", 1'b0, 0, 1'b1, 4'h8, {8'(v), 24'h0});
      bus("R12", 1'b1, 16, 1'b0, 4'hF, '0);
      // R7: lane 2 with mode nonzero writes bytes 2 and 3
      bus("R7", 1'b0, 0, 1'b1, 4'h4, 32'h00A7_0000);
      bus("R5", 1'b0, 0, 1'b1, 4'h2, 32'h0000_0200);
      for (int i = 0; i < 4; i++) bus("R7", 1'b0, 0, 1'b0, 4'h1, '0);
      // R8: every byte-enable pattern on a word-0 write
      for (int k = 1; k < 16; k++)
         bus("R8", 1'b0, 0, 1'b1, 4'(k),
             {8'(160 + k), 8'(176 + k), 8'(192 + k), 8'(208 + k)});
      bus("R8", 1'b0, 0, 1'b1, 4'h2, 32'h0000_0300);
      for (int i = 0; i < 8; i++) bus("R8", 1'b0, 0, 1'b0, 4'h1, '0);
      bus("R12", 1'b1, 16, 1'b0, 4'hF, '0);
      // R1: second reset clears flag, keeps buffer
      do_reset();
      bus("R1", 1'b1, 16, 1'b0, 4'hF, '0);
      for (int i = 0; i < 8; i++) bus("R1", 1'b0, 0, 1'b0, 4'h1, '0);
      idle();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #400000;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule